// File: doc/BRIEF.md
# Program Sequencer with Return-Address Stack

This block is the program-flow unit of a single-cycle soft processor whose program memory is a synchronous block RAM. It keeps a 10-bit program counter, which it drives out as the fetch address, and a circular return-address stack whose depth is a parameter. Each enabled cycle it looks at the instruction the memory delivers, together with the processor's zero and carry flags. It decides whether a jump, call or return is taken, and it produces the next fetch address.

Program memory answers one cycle after it is addressed. When a branch is taken, the word already on its way from the following address is therefore stale. The sequencer marks that word as not to be executed, so a taken branch costs two cycles and every other instruction costs one. A clock-enable input freezes all state, which lets the processor run at a fraction of the clock rate inside one clock domain. Instructions outside the flow group, including the two interrupt-related opcodes, only advance the counter.

Top module: `flow_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_addr` becomes 0 and `exec_valid` becomes 0. The first word delivered after reset is never executed, and `exec_valid` rises one enabled cycle later.
- R2: When the executed word is not a taken branch, `fetch_addr` increases by one on each enabled cycle and `exec_valid` is 1 in the next cycle.
- R3: A word with bits 17..13 = 11010 and bit 12 = 0 is an unconditional jump. The next `fetch_addr` is the word's bits 9..0.
- R4: With bit 12 = 1, a jump, call or return is taken only if its condition holds. The condition is chosen by bits 11..10: 00 needs `zf`=1, 01 needs `zf`=0, 10 needs `cf`=1, 11 needs `cf`=0. When the condition fails, the word takes one cycle and `fetch_addr` advances by one.
- R5: In the cycle after a taken branch, `exec_valid` is 0. The word delivered in that cycle has no effect, even if it is itself a branch.
- R6: A word with bits 17..13 = 11000 is a call. When taken, it goes to bits 9..0 and pushes the address following the call.
- R7: A word with bits 17..13 = 10101 is a return. When taken, it goes to the most recently pushed address that has not yet been popped, in last-in first-out order across nested calls.
- R8: While `en` is 0, `fetch_addr`, `exec_valid` and the stack hold their values. A branch pending at that time is taken once `en` returns to 1.
- R9: The stack is circular with 2**STACK_AW entries and raises no error. With the default of 8 entries, nine nested calls overwrite the oldest saved address, and the ninth return then resumes at the address saved by the ninth call.
- R10: Opcodes 11100 and 11110, and every opcode other than the three flow opcodes, only advance `fetch_addr` by one, whatever their low bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; when 0, all state is held |
| instr | input | 18 | Word from program memory, addressed one cycle earlier |
| zf | input | 1 | Zero flag from the data path |
| cf | input | 1 | Carry flag from the data path |
| fetch_addr | output | 10 | Registered program-memory address |
| exec_valid | output | 1 | The current word is to be executed (not squashed) |

## Verification
Two functions can fall in the same cycle. The first is a taken branch meeting the squash of the word that follows it. The bench places a second jump right after a taken jump and checks that the squashed slot does not redirect the flow. The second is a freeze meeting a pending branch. The bench drops `en` while a jump sits on the memory output, checks that the address holds, and then checks that the jump lands once `en` returns. Stack pushes and pops are judged by the landing address after every call and return, including the wrap that occurs when the call depth passes the stack size.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam logic [4:0] OPC_JUMP = 5'b11010;
  localparam logic [4:0] OPC_CALL = 5'b11000;
  localparam logic [4:0] OPC_RET  = 5'b10101;

  typedef enum logic [1:0] {
    CC_ZSET = 2'b00,
    CC_ZCLR = 2'b01,
    CC_CSET = 2'b10,
    CC_CCLR = 2'b11
  } cond_e;
endpackage

// File: rtl/flow_decode.sv
module flow_decode
  import flow_pkg::*;
#(
  parameter int IW  = 18,
  parameter int PCW = 10
) (
  input  logic [IW-1:0]  instr,
  input  logic           live,
  input  logic           zf,
  input  logic           cf,
  output logic           take,
  output logic           push,
  output logic           pop,
  output logic [PCW-1:0] dest
);
  localparam int OP_LSB = IW - 5;
  localparam int CB     = OP_LSB - 1;

  logic [4:0] opc;
  logic       gated;
  cond_e      cc;
  logic       cond_ok;
  logic       is_j, is_c, is_r;

  assign opc   = instr[IW-1:OP_LSB];
  assign gated = instr[CB];
  assign cc    = cond_e'(instr[CB-1:CB-2]);
  assign dest  = instr[PCW-1:0];

  assign is_j = (opc == OPC_JUMP);
  assign is_c = (opc == OPC_CALL);
  assign is_r = (opc == OPC_RET);

  always_comb begin
    unique case (cc)
      CC_ZSET: cond_ok = zf;
      CC_ZCLR: cond_ok = !zf;
      CC_CSET: cond_ok = cf;
      default: cond_ok = !cf;
    endcase
    if (!gated) cond_ok = 1'b1;
  end

  assign take = live && (is_j || is_c || is_r) && cond_ok;
  assign push = take && is_c;
  assign pop  = take && is_r;

  always_comb begin
    // R6 / R7: a word cannot both push and pop
    push_pop_excl_chk: assert (!(push && pop));
  end
endmodule

// File: rtl/flow_stack.sv
module flow_stack #(
  parameter int PCW      = 10,
  parameter int STACK_AW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           push,
  input  logic           pop,
  input  logic [PCW-1:0] wdata,
  output logic [PCW-1:0] top
);
  localparam int DEPTH = 2 ** STACK_AW;

  logic [PCW-1:0]      mem [DEPTH];
  logic [STACK_AW-1:0] sp;
  logic [STACK_AW-1:0] sp_dn;

  assign sp_dn = sp - STACK_AW'(1);
  assign top   = mem[sp_dn];

  always_ff @(posedge clk) begin
    if (en && push) mem[sp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) sp <= '0;
    else if (en) begin
      if (push)     sp <= sp + STACK_AW'(1);
      else if (pop) sp <= sp_dn;
    end
  end

  // R6
  push_moves_up_chk: assert property (@(posedge clk) disable iff (rst)
    (en && push) |=> (sp == $past(sp) + STACK_AW'(1)));

  // R7
  pop_moves_down_chk: assert property (@(posedge clk) disable iff (rst)
    (en && pop) |=> (sp == $past(sp) - STACK_AW'(1)));

  // R8
  sp_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sp));
endmodule

// File: rtl/flow_pc.sv
module flow_pc #(
  parameter int PCW = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           take,
  input  logic [PCW-1:0] target,
  output logic [PCW-1:0] pc,
  output logic           live
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      live <= 1'b0;
    end else if (en) begin
      pc   <= take ? target : pc + PCW'(1);
      live <= !take;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc == '0 && !live));

  // R5
  squash_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (en && take) |=> !live);

  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !take) |=> (live && pc == $past(pc) + PCW'(1)));

  // R8
  pc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(pc) && $stable(live)));
endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer #(
  parameter int IW       = 18,
  parameter int PCW      = 10,
  parameter int STACK_AW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [IW-1:0]  instr,
  input  logic           zf,
  input  logic           cf,
  output logic [PCW-1:0] fetch_addr,
  output logic           exec_valid
);
  logic           take, push, pop;
  logic [PCW-1:0] dest, top, target, pc;
  logic           live;

  flow_decode #(.IW(IW), .PCW(PCW)) u_dec (
    .instr(instr), .live(live), .zf(zf), .cf(cf),
    .take(take), .push(push), .pop(pop), .dest(dest)
  );

  // pc already points at the word after the call: that is the return address
  flow_stack #(.PCW(PCW), .STACK_AW(STACK_AW)) u_stk (
    .clk(clk), .rst(rst), .en(en), .push(push), .pop(pop),
    .wdata(pc), .top(top)
  );

  assign target = pop ? top : dest;

  flow_pc #(.PCW(PCW)) u_pc (
    .clk(clk), .rst(rst), .en(en), .take(take), .target(target),
    .pc(pc), .live(live)
  );

  assign fetch_addr = pc;
  assign exec_valid = live;
endmodule

// File: tb/tb_flow_sequencer.sv
module tb_flow_sequencer;
  localparam int IW = 18, PCW = 10, SAW = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           en  = 1'b1;
  logic           zf  = 1'b0;
  logic           cf  = 1'b0;
  logic [IW-1:0]  instr;
  logic [PCW-1:0] fetch_addr;
  logic           exec_valid;

  logic [IW-1:0] rom [1024];
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) if (en) instr <= rom[fetch_addr];

  flow_sequencer #(.IW(IW), .PCW(PCW), .STACK_AW(SAW)) dut (
    .clk(clk), .rst(rst), .en(en), .instr(instr), .zf(zf), .cf(cf),
    .fetch_addr(fetch_addr), .exec_valid(exec_valid)
  );

  function automatic logic [17:0] br(logic [4:0] op, logic g, logic [1:0] cc, int t);
    return {op, g, cc, 10'(t)};
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 1024; i++) rom[i] = '0;
  endtask

  task automatic do_reset();
    en = 1'b1; rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    clear_rom(); do_reset();
    chk("R1 addr", fetch_addr, 0);
    chk("R1 valid", exec_valid, 0);
    step();
    chk("R1 valid after", exec_valid, 1);
    chk("R1 addr after", fetch_addr, 1);
  endtask

  task automatic t_seq();
    clear_rom(); do_reset();
    step(5);
    chk("R2 addr", fetch_addr, 5);
    chk("R2 valid", exec_valid, 1);
  endtask

  task automatic t_jump();
    clear_rom();
    rom[2] = br(5'b11010, 0, 2'b00, 100);
    rom[3] = br(5'b11010, 0, 2'b00, 200);
    do_reset();
    step(4);
    chk("R3 jump target", fetch_addr, 100);
    chk("R5 squash valid", exec_valid, 0);
    step();
    chk("R5 squashed jump ignored", fetch_addr, 101);
    chk("R5 valid back", exec_valid, 1);
  endtask

  task automatic t_cond();
    for (int cc = 0; cc < 4; cc++) begin
      for (int f = 0; f < 2; f++) begin
        bit exp_take;
        clear_rom();
        rom[0] = br(5'b11010, 1, 2'(cc), 50);
        zf = (cc < 2) ? f[0] : 1'b0;
        cf = (cc < 2) ? 1'b0 : f[0];
        exp_take = (cc == 0) ? f[0] : (cc == 1) ? !f[0] : (cc == 2) ? f[0] : !f[0];
        do_reset();
        step(2);
        chk($sformatf("R4 cc=%0d flag=%0d", cc, f), fetch_addr, exp_take ? 50 : 2);
        chk("R4 valid", exec_valid, exp_take ? 0 : 1);
      end
    end
    zf = 0; cf = 0;
  endtask

  task automatic t_call_ret();
    clear_rom();
    rom[1]  = br(5'b11000, 0, 2'b00, 40);
    rom[41] = br(5'b11000, 0, 2'b00, 60);
    rom[60] = br(5'b10101, 1, 2'b01, 0);
    rom[42] = br(5'b10101, 0, 2'b00, 0);
    zf = 0;
    do_reset();
    step(3);  chk("R6 call target", fetch_addr, 40);
    step(3);  chk("R6 nested call", fetch_addr, 60);
    step(2);  chk("R7 cond return inner", fetch_addr, 42);
    step(2);  chk("R7 return outer", fetch_addr, 2);
    // same program, return condition fails
    zf = 1;
    do_reset();
    step(8);
    chk("R4 R7 return not taken", fetch_addr, 62);
    chk("R4 R7 valid", exec_valid, 1);
    zf = 0;
  endtask

  task automatic t_enable();
    clear_rom();
    rom[2] = br(5'b11010, 0, 2'b00, 30);
    do_reset();
    step(3);
    en = 1'b0;
    step(4);
    chk("R8 addr held", fetch_addr, 3);
    chk("R8 valid held", exec_valid, 1);
    en = 1'b1;
    step();
    chk("R8 pending jump lands", fetch_addr, 30);
  endtask

  task automatic t_wrap();
    clear_rom();
    for (int k = 0; k < 9; k++) rom[k*10] = br(5'b11000, 0, 2'b00, k*10 + 10);
    rom[90] = br(5'b10101, 0, 2'b00, 0);
    for (int k = 1; k < 9; k++) rom[k*10 + 1] = br(5'b10101, 0, 2'b00, 0);
    do_reset();
    step(20); chk("R9 first return", fetch_addr, 81);
    step(2);  chk("R9 second return", fetch_addr, 71);
    step(14); chk("R9 wrapped return", fetch_addr, 81);
  endtask

  task automatic t_nop();
    clear_rom();
    rom[0] = {5'b11100, 13'h1fff};
    rom[1] = {5'b11110, 13'h0155};
    rom[2] = {5'b11001, 13'h0044};
    rom[3] = {5'b10100, 13'h0022};
    do_reset();
    step(5);
    chk("R10 addr", fetch_addr, 5);
    chk("R10 valid", exec_valid, 1);
  endtask

  initial begin
    t_reset();
    t_seq();
    t_jump();
    t_cond();
    t_call_ret();
    t_enable();
    t_wrap();
    t_nop();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule